// File: doc/BRIEF.md
# One-Time Fuse Array Access Controller

This block sequences single-byte reads and bit-by-bit programming of a 512-byte one-time-programmable fuse macro. Software uses a small register port to load a fuse address, an operation mode, a 32-bit program word and three timing counts. It then writes the launch bit and polls that same bit until it drops. A read pulses the macro's read strobe for a programmed time and captures one byte into a readback register. A program operation walks the selected data bits in order. It gives each bit that is 1 its own program-strobe pulse, with the target address and a 3-bit bit-select held steady. Bits that are 0 are skipped, because a fuse can only move from 0 to 1. Multi-byte reads are left to software, which repeats single-byte reads.

Timing is counted in ticks. A divider count sets the number of clock cycles per tick. The read count and the program count give the strobe lengths in ticks. A count of zero acts as one. The sequencer has five states:

- `ST_IDLE` waits for a launch. A read goes to `ST_RD_STROBE`. A word program whose base is out of range goes to `ST_DONE`. Any other program goes to `ST_PG_SCAN`.
- `ST_RD_STROBE` holds the read strobe. On its last tick it captures the byte and goes to `ST_DONE`.
- `ST_PG_SCAN` looks at one data bit per cycle. A 1 bit goes to `ST_PG_PULSE`. A 0 bit steps to the next bit, or goes to `ST_DONE` after the last bit.
- `ST_PG_PULSE` holds the program strobe. When its time ends, it steps to the next bit back in `ST_PG_SCAN`, or goes to `ST_DONE` after the last bit.
- `ST_DONE` lasts one cycle and returns to `ST_IDLE`.

Top module: `otp_fuse_ctrl`

## Requirements
- R1: After reset the busy output is 0, the launch bit (offset 0, bit 0) reads 0 and the readback register (offset 4) reads 0. The three timing counts read back nonzero: read count at offset 5, program count at offset 6, divider count at offset 7.
- R2: Writing a word with bit 0 set to offset 0 while idle starts an operation. Offset 0 bit 0 and the busy output read 1 until the operation finishes and 0 afterwards. No strobe is active while idle.
- R3: The mode register is at offset 2. Its bit 0 selects read (0) or program (1), and its bit 1 selects byte (0) or word (1) programming. With bit 0 clear, the block reads the byte at the address held at offset 1 (9 bits). The readback at offset 4 returns that byte in bits 7:0, and its bits 31:8 read 0.
- R4: The read strobe stays high for exactly max(div,1)*max(rdcnt,1) clock cycles.
- R5: A byte program pulses once for each 1 bit of bits 7:0 of the program word (offset 3), in ascending bit order. Bits 31:8 are ignored. The address and bit-select stay stable during each pulse. A data byte of 0 produces no pulse.
- R6: Each program pulse lasts exactly max(div,1)*max(pgcnt,1) clock cycles, and pulses are separated by at least one low cycle.
- R7: A word program burns bits 8i+7:8i of the program word at address base+i, for i from 0 up to 3 in order (little-endian), with ascending bits within each byte.
- R8: A word program whose base is above 0x1FC produces no pulse and still completes, with the launch bit clearing.
- R9: While busy, writes to offsets 1, 2, 3, 5, 6 and 7 are ignored, and a second launch has no effect.
- R10: The read and program strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 3 | Register word offset for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| busy | output | 1 | Operation in progress |
| fuse_addr | output | 9 | Fuse macro byte address |
| fuse_rd_stb | output | 1 | Fuse macro read strobe |
| fuse_pgm_stb | output | 1 | Fuse macro program strobe |
| fuse_bit_sel | output | 3 | Bit being programmed |
| fuse_q | input | 8 | Fuse macro read data |

## Verification
The hardest situation to reach is a register write or a second launch that arrives in the middle of a long program pulse. The stimulus gets there by choosing large divider and program counts, so that one byte program lasts dozens of cycles, and then issuing conflicting writes and a relaunch straight after the launch. Reading the registers back afterwards and matching the exact pulse list shows that nothing changed. Rejection of an out-of-range word base is reached by aiming a word program at 0x1FD, just past the last legal base.

// File: rtl/otp_fuse_pkg.sv
package otp_fuse_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_STROBE,
        ST_PG_SCAN,
        ST_PG_PULSE,
        ST_DONE
    } seq_state_t;

    localparam logic [2:0] OFS_CTRL   = 3'd0;
    localparam logic [2:0] OFS_ADDR   = 3'd1;
    localparam logic [2:0] OFS_MODE   = 3'd2;
    localparam logic [2:0] OFS_PDATA  = 3'd3;
    localparam logic [2:0] OFS_RBACK  = 3'd4;
    localparam logic [2:0] OFS_RDCNT  = 3'd5;
    localparam logic [2:0] OFS_PGCNT  = 3'd6;
    localparam logic [2:0] OFS_DIVCNT = 3'd7;

endpackage

// File: rtl/otp_regfile.sv
module otp_regfile
    import otp_fuse_pkg::*;
#(
    parameter int ADDR_W  = 9,
    parameter int CNT_W   = 16,
    parameter int RD_DEF  = 4,
    parameter int PG_DEF  = 8,
    parameter int DIV_DEF = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              busy,
    input  logic              cap_en,
    input  logic [7:0]        cap_byte,
    output logic              launch,
    output logic [ADDR_W-1:0] cfg_addr,
    output logic              cfg_prog,
    output logic              cfg_word,
    output logic [31:0]       cfg_pdata,
    output logic [CNT_W-1:0]  cnt_rd,
    output logic [CNT_W-1:0]  cnt_pg,
    output logic [CNT_W-1:0]  cnt_div
);

    logic       wr_ok;
    logic [7:0] rback_q;

    assign wr_ok  = reg_we && !busy;
    assign launch = wr_ok && (reg_addr == OFS_CTRL) && reg_wdata[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_addr  <= '0;
            cfg_prog  <= 1'b0;
            cfg_word  <= 1'b0;
            cfg_pdata <= '0;
            cnt_rd    <= CNT_W'(RD_DEF);
            cnt_pg    <= CNT_W'(PG_DEF);
            cnt_div   <= CNT_W'(DIV_DEF);
        end else if (wr_ok) begin
            case (reg_addr)
                OFS_ADDR:   cfg_addr  <= reg_wdata[ADDR_W-1:0];
                OFS_MODE:   {cfg_word, cfg_prog} <= reg_wdata[1:0];
                OFS_PDATA:  cfg_pdata <= reg_wdata;
                OFS_RDCNT:  cnt_rd    <= reg_wdata[CNT_W-1:0];
                OFS_PGCNT:  cnt_pg    <= reg_wdata[CNT_W-1:0];
                OFS_DIVCNT: cnt_div   <= reg_wdata[CNT_W-1:0];
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rback_q <= '0;
        end else if (cap_en) begin
            rback_q <= cap_byte;
        end
    end

    always_comb begin
        case (reg_addr)
            OFS_CTRL:   reg_rdata = {31'd0, busy};
            OFS_ADDR:   reg_rdata = 32'(cfg_addr);
            OFS_MODE:   reg_rdata = {30'd0, cfg_word, cfg_prog};
            OFS_PDATA:  reg_rdata = cfg_pdata;
            OFS_RBACK:  reg_rdata = {24'd0, rback_q};
            OFS_RDCNT:  reg_rdata = 32'(cnt_rd);
            OFS_PGCNT:  reg_rdata = 32'(cnt_pg);
            default:    reg_rdata = 32'(cnt_div);
        endcase
    end

endmodule

// File: rtl/otp_tick_gen.sv
module otp_tick_gen #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [CNT_W-1:0] div_cnt,
    output logic             tick
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] lim;
    logic [CNT_W-1:0] cnt_q;

    assign lim  = (div_cnt == '0) ? ONE : div_cnt;
    assign tick = (cnt_q == lim - ONE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + ONE;
        end
    end

endmodule

// File: rtl/otp_seq.sv
module otp_seq
    import otp_fuse_pkg::*;
#(
    parameter int ADDR_W     = 9,
    parameter int CNT_W      = 16,
    parameter int FUSE_BYTES = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic              cfg_prog,
    input  logic              cfg_word,
    input  logic [31:0]       cfg_pdata,
    input  logic [CNT_W-1:0]  cnt_rd,
    input  logic [CNT_W-1:0]  cnt_pg,
    input  logic              tick,
    input  logic [7:0]        fuse_q,
    output logic              busy,
    output logic              restart,
    output logic              cap_en,
    output logic [7:0]        cap_byte,
    output logic [ADDR_W-1:0] fuse_addr,
    output logic              fuse_rd_stb,
    output logic              fuse_pgm_stb,
    output logic [2:0]        fuse_bit_sel
);

    localparam int               WORD_MAX = FUSE_BYTES - 4;
    localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

    seq_state_t       state_q, state_d;
    logic [1:0]       byte_q, byte_d;
    logic [2:0]       bit_q, bit_d;
    logic [CNT_W-1:0] ph_q, ph_d;

    logic [CNT_W-1:0] rd_need, pg_need;
    logic [7:0]       cur_byte;
    logic             cur_bit, last_bit, last_byte, word_bad, step;

    assign rd_need   = (cnt_rd == '0) ? ONE : cnt_rd;
    assign pg_need   = (cnt_pg == '0) ? ONE : cnt_pg;
    assign cur_byte  = cfg_pdata[{byte_q, 3'b000} +: 8];
    assign cur_bit   = cur_byte[bit_q];
    assign last_bit  = (bit_q == 3'd7);
    assign last_byte = !cfg_word || (byte_q == 2'd3);
    assign word_bad  = cfg_word && (int'(cfg_addr) > WORD_MAX);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            byte_q  <= '0;
            bit_q   <= '0;
            ph_q    <= '0;
        end else begin
            state_q <= state_d;
            byte_q  <= byte_d;
            bit_q   <= bit_d;
            ph_q    <= ph_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        byte_d  = byte_q;
        bit_d   = bit_q;
        ph_d    = ph_q;
        restart = 1'b0;
        cap_en  = 1'b0;
        step    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (launch) begin
                    byte_d = '0;
                    bit_d  = '0;
                    ph_d   = '0;
                    if (!cfg_prog) begin
                        state_d = ST_RD_STROBE;
                        restart = 1'b1;
                    end else if (word_bad) begin
                        state_d = ST_DONE;
                    end else begin
                        state_d = ST_PG_SCAN;
                    end
                end
            end
            ST_RD_STROBE: begin
                if (tick) begin
                    if (ph_q == rd_need - ONE) begin
                        cap_en  = 1'b1;
                        state_d = ST_DONE;
                    end else begin
                        ph_d = ph_q + ONE;
                    end
                end
            end
            ST_PG_SCAN: begin
                if (cur_bit) begin
                    state_d = ST_PG_PULSE;
                    restart = 1'b1;
                    ph_d    = '0;
                end else begin
                    step = 1'b1;
                end
            end
            ST_PG_PULSE: begin
                if (tick) begin
                    if (ph_q == pg_need - ONE) begin
                        step = 1'b1;
                    end else begin
                        ph_d = ph_q + ONE;
                    end
                end
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase

        if (step) begin
            if (last_bit) begin
                bit_d = '0;
                if (last_byte) begin
                    state_d = ST_DONE;
                end else begin
                    byte_d  = byte_q + 2'd1;
                    state_d = ST_PG_SCAN;
                end
            end else begin
                bit_d   = bit_q + 3'd1;
                state_d = ST_PG_SCAN;
            end
        end
    end

    // outputs
    always_comb begin
        busy         = (state_q != ST_IDLE);
        fuse_rd_stb  = (state_q == ST_RD_STROBE);
        fuse_pgm_stb = (state_q == ST_PG_PULSE);
        fuse_addr    = cfg_addr + ADDR_W'(byte_q);
        fuse_bit_sel = bit_q;
        cap_byte     = fuse_q;
    end

endmodule

// File: rtl/otp_fuse_ctrl.sv
module otp_fuse_ctrl #(
    parameter int FUSE_BYTES = 512,
    parameter int CNT_W      = 16,
    parameter int RD_DEF     = 4,
    parameter int PG_DEF     = 8,
    parameter int DIV_DEF    = 2,
    localparam int ADDR_W    = $clog2(FUSE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              busy,
    output logic [ADDR_W-1:0] fuse_addr,
    output logic              fuse_rd_stb,
    output logic              fuse_pgm_stb,
    output logic [2:0]        fuse_bit_sel,
    input  logic [7:0]        fuse_q
);

    logic              launch, restart, tick, cap_en;
    logic [7:0]        cap_byte;
    logic [ADDR_W-1:0] cfg_addr;
    logic              cfg_prog, cfg_word;
    logic [31:0]       cfg_pdata;
    logic [CNT_W-1:0]  cnt_rd, cnt_pg, cnt_div;

    otp_regfile #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W),
        .RD_DEF (RD_DEF),
        .PG_DEF (PG_DEF),
        .DIV_DEF(DIV_DEF)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_we   (reg_we),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .busy     (busy),
        .cap_en   (cap_en),
        .cap_byte (cap_byte),
        .launch   (launch),
        .cfg_addr (cfg_addr),
        .cfg_prog (cfg_prog),
        .cfg_word (cfg_word),
        .cfg_pdata(cfg_pdata),
        .cnt_rd   (cnt_rd),
        .cnt_pg   (cnt_pg),
        .cnt_div  (cnt_div)
    );

    otp_tick_gen #(
        .CNT_W(CNT_W)
    ) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(restart),
        .div_cnt(cnt_div),
        .tick   (tick)
    );

    otp_seq #(
        .ADDR_W    (ADDR_W),
        .CNT_W     (CNT_W),
        .FUSE_BYTES(FUSE_BYTES)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .launch      (launch),
        .cfg_addr    (cfg_addr),
        .cfg_prog    (cfg_prog),
        .cfg_word    (cfg_word),
        .cfg_pdata   (cfg_pdata),
        .cnt_rd      (cnt_rd),
        .cnt_pg      (cnt_pg),
        .tick        (tick),
        .fuse_q      (fuse_q),
        .busy        (busy),
        .restart     (restart),
        .cap_en      (cap_en),
        .cap_byte    (cap_byte),
        .fuse_addr   (fuse_addr),
        .fuse_rd_stb (fuse_rd_stb),
        .fuse_pgm_stb(fuse_pgm_stb),
        .fuse_bit_sel(fuse_bit_sel)
    );

endmodule

// File: rtl/otp_fuse_ctrl_chk.sv
module otp_fuse_ctrl_chk #(
    parameter int ADDR_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        reg_addr,
    input logic [31:0]       reg_rdata,
    input logic              busy,
    input logic [ADDR_W-1:0] fuse_addr,
    input logic              fuse_rd_stb,
    input logic              fuse_pgm_stb,
    input logic [2:0]        fuse_bit_sel,
    input logic [ADDR_W-1:0] cfg_addr,
    input logic              cfg_prog,
    input logic              cfg_word,
    input logic [31:0]       cfg_pdata
);

    localparam int WORD_MAX = (1 << ADDR_W) - 4;

    p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(fuse_rd_stb && fuse_pgm_stb));

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!fuse_rd_stb && !fuse_pgm_stb));

    p_pulse_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fuse_pgm_stb && $past(fuse_pgm_stb)) |-> ($stable(fuse_addr) && $stable(fuse_bit_sel)));

    p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |->
            ($stable(cfg_addr) && $stable(cfg_prog) && $stable(cfg_word) && $stable(cfg_pdata)));

    p_rback_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 3'd4) |-> (reg_rdata[31:8] == 24'd0));

    p_word_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fuse_pgm_stb && cfg_word) |-> (int'(cfg_addr) <= WORD_MAX));

endmodule

bind otp_fuse_ctrl otp_fuse_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_addr    (reg_addr),
    .reg_rdata   (reg_rdata),
    .busy        (busy),
    .fuse_addr   (fuse_addr),
    .fuse_rd_stb (fuse_rd_stb),
    .fuse_pgm_stb(fuse_pgm_stb),
    .fuse_bit_sel(fuse_bit_sel),
    .cfg_addr    (cfg_addr),
    .cfg_prog    (cfg_prog),
    .cfg_word    (cfg_word),
    .cfg_pdata   (cfg_pdata)
);

// File: tb/otp_fuse_ctrl_tb.sv
module otp_fuse_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        busy;
    logic [8:0]  fuse_addr;
    logic        fuse_rd_stb, fuse_pgm_stb;
    logic [2:0]  fuse_bit_sel;
    logic [7:0]  fuse_q;

    always #4 clk = ~clk;   // 125 MHz

    otp_fuse_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
        .fuse_addr(fuse_addr), .fuse_rd_stb(fuse_rd_stb), .fuse_pgm_stb(fuse_pgm_stb),
        .fuse_bit_sel(fuse_bit_sel), .fuse_q(fuse_q)
    );

    // fuse array model
    logic [7:0] fuse_mem [512];
    assign fuse_q = fuse_rd_stb ? fuse_mem[fuse_addr] : 8'h00;

    int checks = 0;
    int fails  = 0;
    int tb_div = 2, tb_rd = 4, tb_pg = 8;

    // scoreboard: {is_pgm, addr, bit} and width
    logic [12:0] exp_ev [$];
    int          exp_w  [$];

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int eff(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    // monitor
    int          run = 0;
    logic [12:0] cur_ev;
    always @(negedge clk) begin
        if (fuse_rd_stb || fuse_pgm_stb) begin
            if (run == 0)
                cur_ev = {fuse_pgm_stb, fuse_addr, fuse_pgm_stb ? fuse_bit_sel : 3'd0};
            run++;
        end else if (run > 0) begin
            if (cur_ev[12])
                fuse_mem[cur_ev[11:3]][cur_ev[2:0]] = 1'b1;
            if (exp_ev.size() == 0) begin
                check(1'b0, "R5 unexpected pulse", cur_ev, 0);
            end else begin
                logic [12:0] e;
                int w;
                e = exp_ev.pop_front();
                w = exp_w.pop_front();
                check(cur_ev == e, "R5/R7 pulse kind/addr/bit", cur_ev, e);
                check(run == w, cur_ev[12] ? "R6 pulse width" : "R4 strobe width", run, w);
            end
            run = 0;
        end
    end

    task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle(input string req);
        logic [31:0] v;
        int n = 0;
        v = 32'd1;
        while (v[0] && n < 5000) begin
            reg_read(3'd0, v);
            n++;
        end
        check(v[0] == 1'b0 && busy == 1'b0, req, v, 0);
    endtask

    task automatic set_timing(input int d, input int r, input int p);
        tb_div = d; tb_rd = r; tb_pg = p;
        reg_write(3'd7, d);
        reg_write(3'd5, r);
        reg_write(3'd6, p);
    endtask

    task automatic do_read(input logic [8:0] a);
        logic [31:0] v;
        logic [7:0]  expv;
        expv = fuse_mem[a];
        reg_write(3'd1, 32'(a));
        reg_write(3'd2, 32'd0);
        exp_ev.push_back({1'b0, a, 3'd0});
        exp_w.push_back(eff(tb_div) * eff(tb_rd));
        reg_write(3'd0, 32'd1);
        reg_read(3'd0, v);
        check(v[0] == 1'b1 && busy, "R2 launch bit reads 1 while busy", v, 1);
        wait_idle("R2 launch bit clears");
        reg_read(3'd4, v);
        check(v == {24'd0, expv}, "R3 readback byte", v, expv);
    endtask

    task automatic do_prog(input logic [8:0] a, input logic [31:0] d, input bit word);
        int nb = word ? 4 : 1;
        reg_write(3'd1, 32'(a));
        reg_write(3'd3, d);
        reg_write(3'd2, {30'd0, word, 1'b1});
        for (int b = 0; b < nb; b++)
            for (int i = 0; i < 8; i++)
                if (d[8*b+i]) begin
                    exp_ev.push_back({1'b1, 9'(a + 9'(b)), 3'(i)});
                    exp_w.push_back(eff(tb_div) * eff(tb_pg));
                end
        reg_write(3'd0, 32'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [7:0]  old0, old1, old2, old3;
        for (int i = 0; i < 512; i++) fuse_mem[i] = 8'((i * 29) & 8'h52);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        reg_read(3'd0, v); check(v == 0 && !busy, "R1 launch/busy after reset", v, 0);
        reg_read(3'd4, v); check(v == 0, "R1 readback after reset", v, 0);
        reg_read(3'd5, v); check(v != 0, "R1 read count nonzero", v, 1);
        reg_read(3'd6, v); check(v != 0, "R1 program count nonzero", v, 1);
        reg_read(3'd7, v); check(v != 0, "R1 divider count nonzero", v, 1);

        // R3/R4 reads with several timings
        set_timing(1, 3, 2);
        do_read(9'h010);
        do_read(9'h1FF);
        set_timing(3, 0, 2);
        do_read(9'h000);

        // R5/R6 byte program, upper data bits ignored
        set_timing(2, 0, 2);
        old0 = fuse_mem[9'h020];
        do_prog(9'h020, 32'hFFFF_FFA5, 1'b0);
        wait_idle("R5 byte program completes");
        check(exp_ev.size() == 0, "R5 all byte pulses seen", exp_ev.size(), 0);
        do_read(9'h020);
        check(fuse_mem[9'h020] == (old0 | 8'hA5), "R5 burned byte value", fuse_mem[9'h020], old0 | 8'hA5);

        // R5 zero data byte: no pulses
        set_timing(1, 1, 0);
        old0 = fuse_mem[9'h021];
        do_prog(9'h021, 32'h0000_0000, 1'b0);
        wait_idle("R5 zero byte completes");
        check(fuse_mem[9'h021] == old0, "R5 zero byte leaves cell", fuse_mem[9'h021], old0);

        // R7 word program little-endian at the last legal base
        set_timing(1, 1, 3);
        old0 = fuse_mem[9'h1FC]; old1 = fuse_mem[9'h1FD];
        old2 = fuse_mem[9'h1FE]; old3 = fuse_mem[9'h1FF];
        do_prog(9'h1FC, 32'h8001_0300, 1'b1);
        wait_idle("R7 word program completes");
        check(exp_ev.size() == 0, "R7 all word pulses seen", exp_ev.size(), 0);
        do_read(9'h1FC); do_read(9'h1FD); do_read(9'h1FE); do_read(9'h1FF);
        check(fuse_mem[9'h1FD] == (old1 | 8'h03), "R7 byte1 at base+1", fuse_mem[9'h1FD], old1 | 8'h03);
        check(fuse_mem[9'h1FF] == (old3 | 8'h80), "R7 byte3 at base+3", fuse_mem[9'h1FF], old3 | 8'h80);
        check(fuse_mem[9'h1FC] == old0 && fuse_mem[9'h1FE] == (old2 | 8'h01),
              "R7 byte0/byte2", fuse_mem[9'h1FE], old2 | 8'h01);

        // R8 out-of-range word base rejected
        do_prog(9'h1FD, 32'hFFFF_FFFF, 1'b1);
        exp_ev.delete(); exp_w.delete();   // nothing may pulse
        repeat (2) @(negedge clk);
        check(!busy, "R8 rejected word completes", busy, 0);
        repeat (20) @(negedge clk);
        check(run == 0, "R8 no pulse on rejected word", run, 0);

        // R9 writes and relaunch ignored while busy
        set_timing(4, 1, 4);
        do_prog(9'h030, 32'h0000_0081, 1'b0);
        reg_write(3'd1, 32'h055);
        reg_write(3'd3, 32'h1234_5678);
        reg_write(3'd2, 32'd0);
        reg_write(3'd7, 32'd1);
        reg_write(3'd0, 32'd1);
        wait_idle("R9 busy run completes");
        check(exp_ev.size() == 0, "R9 pulses unchanged", exp_ev.size(), 0);
        reg_read(3'd1, v); check(v == 32'h030, "R9 address kept", v, 32'h030);
        reg_read(3'd3, v); check(v == 32'h81, "R9 program data kept", v, 32'h81);
        reg_read(3'd2, v); check(v == 32'd1, "R9 mode kept", v, 1);
        reg_read(3'd7, v); check(v == 32'd4, "R9 divider kept", v, 4);
        repeat (40) @(negedge clk);
        check(!busy && run == 0, "R9 relaunch had no effect", busy, 0);
        check(exp_ev.size() == 0, "R10 scoreboard empty at end", exp_ev.size(), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule